// File: doc/BRIEF.md
# Serial Port Transmit/Receive FIFO Controller

This block sits between a CPU register port and the shift logic of a synchronous serial port. It keeps a transmit queue and a receive queue. Each queue holds sixteen words of up to sixteen bits. It raises one level-sensitive service request per direction, based on a 4-bit threshold for each. The shifter itself is not part of the block. A ready/valid pair pulls transmit words out of the block, and a valid strobe pushes received words in.

A small mode machine routes every access to the data register. In ST_RUN, CPU writes feed the transmit queue and CPU reads drain the receive queue, while the serial side pops and pushes freely. Setting the test bit moves the machine to ST_TST_TX (select bit 0) or ST_TST_RX (select bit 1). In both test states, CPU writes and reads of the data register land on the chosen queue only, and the serial path is cut. Software can then prove each queue's ordering on its own. A control write carrying the flush bit moves the machine to ST_FLUSH. It stays there for exactly one cycle, during which both queues and both overrun flags are cleared.

The transitions are as follows. From any state, a control write with the flush bit set goes to ST_FLUSH. Any other control write goes to the state its test and select bits decode to. ST_FLUSH always leaves after one cycle, to the state decoded from the stored control bits. Without a control write, the other states hold.

Top module: `spfifo_ctrl`

## Requirements
- R1: After reset, CTRL (address 0) reads 0x000F and STATUS (address 2) reads 0x4040. Both tx_irq and rx_irq are high.
- R2: In run mode, CPU writes to DATA (address 1) enter the transmit queue. ser_tx_valid is high while the queue is non-empty. Each cycle with ser_tx_ready high pops one word, presented on ser_tx_data in write order.
- R3: In run mode, a ser_rx_valid cycle stores ser_rx_data. CPU reads of DATA return stored words in arrival order, and each read removes one word.
- R4: tx_irq is high exactly when the transmit level is less than or equal to CTRL[11:8].
- R5: rx_irq is high exactly when the receive level is greater than or equal to CTRL[15:12].
- R6: With CTRL[4]=1 and CTRL[5]=0, DATA writes push and DATA reads pop the transmit queue, in first-in-first-out order.
- R7: With CTRL[4]=1 and CTRL[5]=1, DATA writes push and DATA reads pop the receive queue, in first-in-first-out order.
- R8: While CTRL[4]=1, ser_tx_valid stays low and no transmit word is popped. ser_rx_valid strobes store nothing.
- R9: The word-size field CTRL[3:0] holding code n selects n+1 bits, and codes 0 to 2 select 4 bits. Bits above the word size are stored as zero, whether the word comes from the CPU or from the serial side.
- R10: CTRL bit 7 is reserved. CTRL bit 6 (flush) always reads 0. Address 3 reads 0, and writes to it change nothing.
- R11: STATUS packs, from low bit to high: transmit level [4:0], full [5], empty [6] and sticky overrun [7], then the same four fields for the receive queue in [12:8], [13], [14] and [15]. A push into a full queue is dropped and sets that queue's overrun flag. A DATA read of an empty queue returns 0 and leaves the level at 0.
- R12: Changing the test or select bits keeps both queues' contents. A CTRL write with bit 6 set empties both queues and clears both overrun flags by the second clock edge after the write.
- R13: A push and a pop of the same queue in one cycle both take effect and leave the level unchanged, even when the queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 2 | Register select: 0 CTRL, 1 DATA, 2 STATUS, 3 reserved |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (pops on DATA) |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data for the addressed register, combinational |
| ser_tx_valid | output | 1 | Transmit word available to the shifter |
| ser_tx_ready | input | 1 | Shifter takes the presented word |
| ser_tx_data | output | 16 | Head of the transmit queue |
| ser_rx_valid | input | 1 | Shifter delivers a received word |
| ser_rx_data | input | 16 | Received word |
| tx_irq | output | 1 | Transmit service request |
| rx_irq | output | 1 | Receive service request |

## Verification
In run mode, two events can land on the same queue in one cycle. On the transmit side, a CPU write can meet a shifter pop. On the receive side, a shifter delivery can meet a CPU read. The bench provokes both by raising the two strobes at the same falling edge. On the transmit side it does this with the queue completely full, where an ordering mistake would drop the write or flag a false overrun. It judges the result by the word presented before the edge, the level and overrun bits read back afterwards, and the order in which the queue later drains.

// File: rtl/spf_pkg.sv
package spf_pkg;

    localparam int BUS_W = 16;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_DATA = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;

    localparam int CB_TEST  = 4;
    localparam int CB_SEL   = 5;
    localparam int CB_FLUSH = 6;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_TST_TX = 2'd1,
        ST_TST_RX = 2'd2,
        ST_FLUSH  = 2'd3
    } spf_mode_e;

    typedef struct packed {
        logic [3:0] rx_thr;
        logic [3:0] tx_thr;
        logic       sel;
        logic       test;
        logic [3:0] wsz;
    } spf_ctrl_t;

    function automatic logic [BUS_W-1:0] word_mask(input logic [3:0] code);
        int n;
        n = (code < 4'd3) ? 4 : int'(code) + 1;
        word_mask = '0;
        for (int i = 0; i < BUS_W; i++) begin
            if (i < n) word_mask[i] = 1'b1;
        end
    endfunction

    function automatic spf_mode_e mode_of(input logic test, input logic sel);
        if (!test) mode_of = ST_RUN;
        else if (sel) mode_of = ST_TST_RX;
        else mode_of = ST_TST_TX;
    endfunction

endpackage

// File: rtl/spf_fifo.sv
module spf_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       full,
    output logic                       empty,
    output logic                       drop
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic          pop_ok, push_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        bump = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (level == '0);
    assign full    = (level == LW'(DEPTH));
    assign pop_ok  = pop && !empty && !clr;
    assign push_ok = push && !clr && (!full || pop_ok);
    assign drop    = push && !clr && !push_ok;
    assign dout    = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= '0;
        end else if (clr) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            if (push_ok && !pop_ok)      level <= level + 1'b1;
            else if (pop_ok && !push_ok) level <= level - 1'b1;
        end
    end

    // R11: level never exceeds capacity
    a_r11_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

    // R11: a push into a full queue without a pop leaves it full
    a_r11_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> (level == LW'(DEPTH)));

    // R11: popping an empty queue keeps it empty
    a_r11_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !clr) |=> (level == '0));

    // R13: simultaneous push and pop keep the level
    a_r13_pushpop_level: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !empty && !clr) |=> $stable(level));

endmodule

// File: rtl/spf_ctrl_regs.sv
module spf_ctrl_regs
    import spf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic [BUS_W-1:0] wdata,
    output spf_ctrl_t        ctrl_q,
    output logic             flush_req,
    output logic [BUS_W-1:0] ctrl_rd
);
    logic unused_rsvd;
    assign unused_rsvd = wdata[7];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{rx_thr: 4'h0, tx_thr: 4'h0, sel: 1'b0, test: 1'b0, wsz: 4'hF};
        end else if (wr_ctrl) begin
            ctrl_q <= '{rx_thr: wdata[15:12], tx_thr: wdata[11:8],
                        sel: wdata[CB_SEL], test: wdata[CB_TEST], wsz: wdata[3:0]};
        end
    end

    assign flush_req = wr_ctrl && wdata[CB_FLUSH];
    assign ctrl_rd   = {ctrl_q.rx_thr, ctrl_q.tx_thr, 2'b00, ctrl_q.sel, ctrl_q.test, ctrl_q.wsz};

endmodule

// File: rtl/spf_mode_fsm.sv
module spf_mode_fsm
    import spf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_ctrl,
    input  logic      wr_test,
    input  logic      wr_sel,
    input  logic      flush_req,
    input  logic      cur_test,
    input  logic      cur_sel,
    input  logic      data_wr,
    input  logic      data_rd,
    input  logic      ser_tx_ready,
    input  logic      ser_rx_valid,
    input  logic      tx_empty,
    output spf_mode_e mode,
    output logic      tx_push,
    output logic      tx_pop,
    output logic      rx_push,
    output logic      rx_pop,
    output logic      rx_from_cpu,
    output logic      rd_from_tx,
    output logic      rd_blank,
    output logic      fifo_clr,
    output logic      ser_tx_valid
);
    spf_mode_e nxt;

    always_comb begin
        if (flush_req)              nxt = ST_FLUSH;
        else if (wr_ctrl)           nxt = mode_of(wr_test, wr_sel);
        else if (mode == ST_FLUSH)  nxt = mode_of(cur_test, cur_sel);
        else                        nxt = mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode <= ST_RUN;
        else        mode <= nxt;
    end

    always_comb begin
        tx_push      = 1'b0;
        tx_pop       = 1'b0;
        rx_push      = 1'b0;
        rx_pop       = 1'b0;
        rx_from_cpu  = 1'b0;
        rd_from_tx   = 1'b0;
        rd_blank     = 1'b0;
        fifo_clr     = 1'b0;
        ser_tx_valid = 1'b0;
        unique case (mode)
            ST_RUN: begin
                tx_push      = data_wr;
                ser_tx_valid = !tx_empty;
                tx_pop       = ser_tx_ready && !tx_empty;
                rx_push      = ser_rx_valid;
                rx_pop       = data_rd;
            end
            ST_TST_TX: begin
                tx_push    = data_wr;
                tx_pop     = data_rd;
                rd_from_tx = 1'b1;
            end
            ST_TST_RX: begin
                rx_push     = data_wr;
                rx_from_cpu = 1'b1;
                rx_pop      = data_rd;
            end
            ST_FLUSH: begin
                fifo_clr = 1'b1;
                rd_blank = 1'b1;
            end
        endcase
    end

    // R12: the flush state lasts a single cycle unless re-requested
    a_r12_flush_leaves: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_FLUSH && !flush_req) |=> (mode != ST_FLUSH));

    // R8: no transmit word is offered outside run mode
    a_r8_no_offer_in_test: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != ST_RUN) |-> !tx_pop || data_rd);

endmodule

// File: rtl/spfifo_ctrl.sv
module spfifo_ctrl
    import spf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cpu_addr,
    input  logic             cpu_wr,
    input  logic             cpu_rd,
    input  logic [BUS_W-1:0] cpu_wdata,
    output logic [BUS_W-1:0] cpu_rdata,
    output logic             ser_tx_valid,
    input  logic             ser_tx_ready,
    output logic [BUS_W-1:0] ser_tx_data,
    input  logic             ser_rx_valid,
    input  logic [BUS_W-1:0] ser_rx_data,
    output logic             tx_irq,
    output logic             rx_irq
);
    localparam int LW = $clog2(DEPTH + 1);

    spf_ctrl_t        ctrl;
    spf_mode_e        mode;
    logic             wr_ctrl, data_wr, data_rd, flush_req;
    logic [BUS_W-1:0] ctrl_rd, mask, tx_din, rx_din, tx_dout, rx_dout, status;
    logic             tx_push, tx_pop, rx_push, rx_pop;
    logic             rx_from_cpu, rd_from_tx, rd_blank, fifo_clr;
    logic [LW-1:0]    tx_lvl, rx_lvl;
    logic             tx_full, tx_empty, rx_full, rx_empty, tx_drop, rx_drop;
    logic             tx_ovr, rx_ovr;

    assign wr_ctrl = cpu_wr && (cpu_addr == A_CTRL);
    assign data_wr = cpu_wr && (cpu_addr == A_DATA);
    assign data_rd = cpu_rd && (cpu_addr == A_DATA);

    spf_ctrl_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wr_ctrl),
        .wdata    (cpu_wdata),
        .ctrl_q   (ctrl),
        .flush_req(flush_req),
        .ctrl_rd  (ctrl_rd)
    );

    spf_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ctrl     (wr_ctrl),
        .wr_test     (cpu_wdata[CB_TEST]),
        .wr_sel      (cpu_wdata[CB_SEL]),
        .flush_req   (flush_req),
        .cur_test    (ctrl.test),
        .cur_sel     (ctrl.sel),
        .data_wr     (data_wr),
        .data_rd     (data_rd),
        .ser_tx_ready(ser_tx_ready),
        .ser_rx_valid(ser_rx_valid),
        .tx_empty    (tx_empty),
        .mode        (mode),
        .tx_push     (tx_push),
        .tx_pop      (tx_pop),
        .rx_push     (rx_push),
        .rx_pop      (rx_pop),
        .rx_from_cpu (rx_from_cpu),
        .rd_from_tx  (rd_from_tx),
        .rd_blank    (rd_blank),
        .fifo_clr    (fifo_clr),
        .ser_tx_valid(ser_tx_valid)
    );

    assign mask   = word_mask(ctrl.wsz);
    assign tx_din = cpu_wdata & mask;
    assign rx_din = (rx_from_cpu ? cpu_wdata : ser_rx_data) & mask;

    spf_fifo #(.DEPTH(DEPTH), .W(BUS_W)) u_txq (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (fifo_clr),
        .push (tx_push),
        .din  (tx_din),
        .pop  (tx_pop),
        .dout (tx_dout),
        .level(tx_lvl),
        .full (tx_full),
        .empty(tx_empty),
        .drop (tx_drop)
    );

    spf_fifo #(.DEPTH(DEPTH), .W(BUS_W)) u_rxq (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (fifo_clr),
        .push (rx_push),
        .din  (rx_din),
        .pop  (rx_pop),
        .dout (rx_dout),
        .level(rx_lvl),
        .full (rx_full),
        .empty(rx_empty),
        .drop (rx_drop)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_ovr <= 1'b0;
            rx_ovr <= 1'b0;
        end else if (fifo_clr) begin
            tx_ovr <= 1'b0;
            rx_ovr <= 1'b0;
        end else begin
            if (tx_drop) tx_ovr <= 1'b1;
            if (rx_drop) rx_ovr <= 1'b1;
        end
    end

    assign ser_tx_data = tx_dout;
    assign tx_irq      = (tx_lvl <= LW'(ctrl.tx_thr));
    assign rx_irq      = (rx_lvl >= LW'(ctrl.rx_thr));
    assign status      = {rx_ovr, rx_empty, rx_full, 5'(rx_lvl),
                          tx_ovr, tx_empty, tx_full, 5'(tx_lvl)};

    always_comb begin
        unique case (cpu_addr)
            A_CTRL:  cpu_rdata = ctrl_rd;
            A_DATA:  cpu_rdata = rd_blank ? '0 : (rd_from_tx ? tx_dout : rx_dout);
            A_STAT:  cpu_rdata = status;
            default: cpu_rdata = '0;
        endcase
    end

    // R8: serial deliveries are discarded in test mode
    a_r8_rx_discard: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == ST_TST_TX || mode == ST_TST_RX) && ser_rx_valid
         && !data_wr && !data_rd && !wr_ctrl) |=> $stable(rx_lvl));

    // R8: shifter handshakes move nothing out in test mode
    a_r8_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == ST_TST_TX || mode == ST_TST_RX) && ser_tx_ready
         && !data_wr && !data_rd && !wr_ctrl) |=> $stable(tx_lvl));

    // R11: overrun flags stay set until a flush
    a_r11_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ovr && !fifo_clr) |=> tx_ovr);

endmodule

// File: tb/test_spfifo_ctrl.sv
module test_spfifo_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cpu_addr = 2'd0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        ser_tx_valid;
    logic        ser_tx_ready = 1'b0;
    logic [15:0] ser_tx_data;
    logic        ser_rx_valid = 1'b0;
    logic [15:0] ser_rx_data = '0;
    logic        tx_irq, rx_irq;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    spfifo_ctrl i_spfifo_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ser_tx_valid(ser_tx_valid),
        .ser_tx_ready(ser_tx_ready), .ser_tx_data(ser_tx_data), .ser_rx_valid(ser_rx_valid),
        .ser_rx_data(ser_rx_data), .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ctrlv(input int wsz, input bit tst, input bit sel,
                                          input int txt, input int rxt);
        ctrlv = {4'(rxt), 4'(txt), 2'b00, sel, tst, 4'(wsz)};
    endfunction

    function automatic logic [15:0] statv(input int txl, input bit txo, input int rxl, input bit rxo);
        statv = {rxo, rxl == 0, rxl == 16, 5'(rxl), txo, txl == 0, txl == 16, 5'(txl)};
    endfunction

    function automatic logic [15:0] maskv(input int code);
        int n;
        n = (code < 3) ? 4 : code + 1;
        maskv = 16'((32'd1 << n) - 1);
    endfunction

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic ser_push(input logic [15:0] d);
        @(negedge clk);
        ser_rx_valid = 1'b1; ser_rx_data = d;
        @(negedge clk);
        ser_rx_valid = 1'b0;
    endtask

    task automatic ser_pop(output logic [15:0] d, output logic v);
        @(negedge clk);
        ser_tx_ready = 1'b1;
        #1 d = ser_tx_data; v = ser_tx_valid;
        @(negedge clk);
        ser_tx_ready = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, d); chk("R1 ctrl", d, 16'h000F);
        rd(2'd2, d); chk("R1 status", d, 16'h4040);
        chk("R1 irqs", {14'd0, tx_irq, rx_irq}, 16'd3);

        // R4 sweep transmit levels 0..16 against every threshold
        for (int l = 0; l <= 16; l++) begin
            for (int t = 0; t < 16; t++) begin
                wr(2'd0, ctrlv(15, 0, 0, t, 0));
                chk($sformatf("R4 tx_irq L=%0d T=%0d", l, t), {15'd0, tx_irq}, {15'd0, l <= t});
            end
            rd(2'd2, d); chk("R4 tx level", d, statv(l, 0, 0, 0));
            if (l < 16) wr(2'd1, 16'hA000 + 16'(l));
        end
        // R2 serial drain in order
        for (int i = 0; i < 16; i++) begin
            ser_pop(d, v);
            chk("R2 tx valid", {15'd0, v}, 16'd1);
            chk("R2 tx order", d, 16'hA000 + 16'(i));
        end
        #1 chk("R2 tx idle", {15'd0, ser_tx_valid}, 16'd0);

        // R5 sweep receive levels 0..16 against every threshold
        for (int l = 0; l <= 16; l++) begin
            for (int t = 0; t < 16; t++) begin
                wr(2'd0, ctrlv(15, 0, 0, 0, t));
                chk($sformatf("R5 rx_irq L=%0d T=%0d", l, t), {15'd0, rx_irq}, {15'd0, l >= t});
            end
            if (l < 16) ser_push(16'h5000 + 16'(l));
        end
        // R3 CPU drain in order
        for (int i = 0; i < 16; i++) begin
            rd(2'd1, d); chk("R3 rx order", d, 16'h5000 + 16'(i));
        end
        // R11 empty read
        rd(2'd1, d); chk("R11 empty read", d, 16'h0000);
        rd(2'd2, d); chk("R11 empty level", d, statv(0, 0, 0, 0));

        // R9 word size on both paths
        for (int c = 0; c < 16; c++) begin
            wr(2'd0, ctrlv(c, 0, 0, 0, 0));
            wr(2'd1, 16'hFFFF);
            ser_pop(d, v); chk($sformatf("R9 tx code %0d", c), d, maskv(c));
            ser_push(16'hFFFF);
            rd(2'd1, d); chk($sformatf("R9 rx code %0d", c), d, maskv(c));
        end

        // R6 test mode on transmit queue, R11 overrun, R8 cut serial path
        wr(2'd0, ctrlv(15, 1, 0, 0, 0));
        for (int i = 0; i < 16; i++) wr(2'd1, 16'h0111 * 16'(i) + 16'd1);
        wr(2'd1, 16'hDEAD);
        rd(2'd2, d); chk("R11 full overrun", d, statv(16, 1, 0, 0));
        @(negedge clk); ser_tx_ready = 1'b1;
        #1 chk("R8 no tx offer", {15'd0, ser_tx_valid}, 16'd0);
        @(negedge clk); @(negedge clk); ser_tx_ready = 1'b0;
        for (int i = 0; i < 3; i++) ser_push(16'h7777);
        rd(2'd2, d); chk("R8 serial ignored", d, statv(16, 1, 0, 0));
        for (int i = 0; i < 16; i++) begin
            rd(2'd1, d); chk("R6 tx fifo order", d, 16'h0111 * 16'(i) + 16'd1);
        end
        rd(2'd1, d); chk("R11 empty tx read", d, 16'h0000);

        // R7 test mode on receive queue
        wr(2'd0, ctrlv(15, 1, 1, 0, 0));
        for (int i = 0; i < 5; i++) wr(2'd1, 16'h3C00 + 16'(i));
        rd(2'd2, d); chk("R7 rx level", d, statv(0, 1, 5, 0));
        for (int i = 0; i < 5; i++) begin
            rd(2'd1, d); chk("R7 rx fifo order", d, 16'h3C00 + 16'(i));
        end

        // R12 mode change keeps contents, flush clears
        wr(2'd0, ctrlv(15, 0, 0, 0, 0));
        for (int i = 0; i < 3; i++) wr(2'd1, 16'h9000 + 16'(i));
        wr(2'd0, ctrlv(15, 1, 1, 0, 0));
        wr(2'd0, ctrlv(15, 0, 0, 0, 0));
        rd(2'd2, d); chk("R12 kept level", d, statv(3, 1, 0, 0));
        #1 chk("R12 kept head", ser_tx_data, 16'h9000);
        wr(2'd0, ctrlv(15, 0, 0, 0, 0) | 16'h0040);
        rd(2'd2, d); chk("R12 flushed", d, 16'h4040);

        // R10 reserved bits and address
        wr(2'd0, 16'hFFFF);
        rd(2'd0, d); chk("R10 ctrl readback", d, 16'hFF3F);
        wr(2'd0, ctrlv(15, 0, 0, 0, 0));
        wr(2'd3, 16'h1234);
        rd(2'd3, d); chk("R10 reserved addr", d, 16'h0000);
        rd(2'd2, d); chk("R10 status untouched", d, 16'h4040);
        rd(2'd0, d); chk("R10 ctrl untouched", d, 16'h000F);

        // R13 simultaneous push and pop on a full transmit queue
        for (int i = 0; i < 16; i++) wr(2'd1, 16'hC000 + 16'(i));
        @(negedge clk);
        cpu_addr = 2'd1; cpu_wdata = 16'hBEEF; cpu_wr = 1'b1; ser_tx_ready = 1'b1;
        #1 chk("R13 tx head", ser_tx_data, 16'hC000);
        @(negedge clk);
        cpu_wr = 1'b0; ser_tx_ready = 1'b0;
        rd(2'd2, d); chk("R13 tx level kept", d, statv(16, 0, 0, 0));
        for (int i = 1; i < 16; i++) begin
            ser_pop(d, v); chk("R13 tx drain", d, 16'hC000 + 16'(i));
        end
        ser_pop(d, v); chk("R13 tx last", d, 16'hBEEF);

        // R13 simultaneous serial push and CPU pop on receive queue
        ser_push(16'h0A01);
        ser_push(16'h0A02);
        @(negedge clk);
        cpu_addr = 2'd1; cpu_rd = 1'b1; ser_rx_valid = 1'b1; ser_rx_data = 16'h0A03;
        #1 chk("R13 rx head", cpu_rdata, 16'h0A01);
        @(negedge clk);
        cpu_rd = 1'b0; ser_rx_valid = 1'b0;
        rd(2'd2, d); chk("R13 rx level kept", d, statv(0, 0, 2, 0));
        rd(2'd1, d); chk("R13 rx next", d, 16'h0A02);
        rd(2'd1, d); chk("R13 rx new", d, 16'h0A03);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule